// File: doc/BRIEF.md
# Four-Lane Parallel GHASH Tag Engine

This block computes the GCM authentication tag for a stream that arrives as one 512-bit beat per clock. Each beat carries four 128-bit blocks. Lane 0 sits in bits [511:384] and is the earliest block in the stream. The block takes no stalls: once it is ready, it folds a full beat into its running hash on every cycle. It does this by multiplying the four lanes by H^4, H^3, H^2 and H in parallel and XOR-ing the four products together.

A one-cycle start pulse does three things:
- It loads a new hash subkey H.
- It clears the running hash.
- It begins a short derivation of H^2, H^3 and H^4, which uses a single multiplier.

While that derivation runs, the ready output stays low.

The last beat of a message may be partly filled. After the last beat, the block folds in the GCM length block with one multiplication by H. It then XORs in the encrypted pre-counter block supplied by the caller, presents the tag and pulses a done flag. Alongside the done flag it gives a pass or fail verdict against an expected tag. The caller must present additional authenticated data as zero-padded 128-bit blocks in the same stream, ahead of the ciphertext.

Top module: `ghash4_engine`

## Requirements
- R1: While reset is asserted and until the first start pulse, ready_o, done_o, pass_o and fail_o are 0 and tag_o is all zeros. Beats offered before the first start pulse are ignored.
- R2: A start_i pulse loads hkey_i and clears the running hash. ready_o is 0 for the three cycles after the edge that samples start_i and is 1 from the fourth such edge onward. start_i takes priority over any beat offered in the same cycle.
- R3: On a full beat accepted while ready_o is 1, the running hash X becomes (X ^ d1)·H^4 ^ d2·H^3 ^ d3·H^2 ^ d4·H. Here d1 is bits [511:384] and d4 is bits [127:0]. Multiplication is over GF(2^128) in the GCM bit-reflected convention, with polynomial x^128 + x^7 + x^2 + x + 1.
- R4: Consecutive beats are accepted on consecutive cycles with no gap while ready_o is 1. A multi-beat message gives the same hash as absorbing its blocks one at a time.
- R5: On a beat with beat_last_i = 1, beat_lanes_i gives the number of valid lanes minus one. The valid lanes are the earliest ones. Later lanes are ignored, and the last valid block is multiplied by H.
- R6: After the last beat, the block {aad_bits_i, data_bits_i} is folded in with one multiplication by H. aad_bits_i occupies the upper 64 bits. Both are captured with the last beat.
- R7: done_o pulses for exactly one cycle, visible after the second edge following the edge that accepts the last beat. At that point tag_o equals the final hash XOR ekj0_i, which is captured with the last beat. tag_o holds its value until the next done pulse.
- R8: With done_o, exactly one of pass_o and fail_o is 1. pass_o is 1 exactly when the tag equals exp_tag_i, which is captured with the last beat. Both are 0 whenever done_o is 0.
- R9: ready_o is 0 during the two finalization cycles. Beats offered while ready_o is 0 have no effect on any tag.
- R10: After done, the running hash is zero, so the next message under the same H starts from a clean state.
- R11: A start pulse in the middle of a message abandons it. The next tag depends only on the blocks sent after the new H is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load new subkey and clear the hash |
| hkey_i | input | 128 | Hash subkey H |
| beat_valid_i | input | 1 | Beat present this cycle |
| beat_last_i | input | 1 | Beat ends the message |
| beat_lanes_i | input | 2 | Valid lanes minus one, on the last beat |
| beat_data_i | input | 512 | Four 128-bit blocks, earliest block in the top bits |
| aad_bits_i | input | 64 | AAD length in bits |
| data_bits_i | input | 64 | Data length in bits |
| ekj0_i | input | 128 | Encrypted pre-counter block |
| exp_tag_i | input | 128 | Expected tag for comparison |
| ready_o | output | 1 | Beats are accepted |
| done_o | output | 1 | One-cycle tag-valid pulse |
| pass_o | output | 1 | Tag matched, with done |
| fail_o | output | 1 | Tag mismatched, with done |
| tag_o | output | 128 | Final tag |

## Verification
The assertions check the cycle-level behaviour on every cycle:
- the fixed delay from the accepted last beat to the done pulse;
- the one-cycle width of that pulse;
- the two-cycle ready gap during finalization;
- the drop of ready after a start pulse;
- the mutually exclusive verdict;
- tag_o holding its value between done pulses.

Only the bench's scenarios can show the arithmetic: the correctness of the aggregated lane products, the power shift on partly filled last beats, the effect of the length block, and that ignored or abandoned beats leave no trace in later tags. They do this by comparing against a block-at-a-time reference model that uses a different multiplication algorithm.

// File: rtl/ghash4_pkg.sv
package ghash4_pkg;

  localparam int BLK_W = 128;
  // Reduction constant for right shifts in the reflected convention
  localparam logic [BLK_W-1:0] GCM_RED = {8'hE1, 120'd0};

  typedef logic [BLK_W-1:0] blk_t;

  typedef enum logic [1:0] {
    PH_RUN = 2'd0,
    PH_LEN = 2'd1,
    PH_FIN = 2'd2
  } phase_t;

  // Shift-and-add GF(2^128) product, bit 127 holds coefficient x^0
  function automatic blk_t gf128_mul(input blk_t x, input blk_t y);
    blk_t z;
    blk_t v;
    z = '0;
    v = y;
    for (int i = 0; i < BLK_W; i++) begin
      if (x[BLK_W-1-i]) z = z ^ v;
      if (v[0]) v = (v >> 1) ^ GCM_RED;
      else      v = v >> 1;
    end
    return z;
  endfunction

endpackage

// File: rtl/ghash4_gfmul.sv
module ghash4_gfmul
  import ghash4_pkg::*;
(
  input  logic [BLK_W-1:0] a_i,
  input  logic [BLK_W-1:0] b_i,
  output logic [BLK_W-1:0] p_o
);

  assign p_o = gf128_mul(a_i, b_i);

endmodule

// File: rtl/ghash4_hpow.sv
module ghash4_hpow
  import ghash4_pkg::*;
#(
  parameter int NPOW = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_i,
  input  logic [BLK_W-1:0]           hkey_i,
  output logic [NPOW-1:0][BLK_W-1:0] pow_o,
  output logic                       ok_o
);

  localparam int SW = $clog2(NPOW + 1);
  localparam int IW = (NPOW > 1) ? $clog2(NPOW) : 1;

  logic [NPOW-1:0][BLK_W-1:0] pow_q, pow_d;
  logic [SW-1:0]              step_q, step_d;
  logic                       ok_q, ok_d;
  logic                       busy;
  logic                       upd;
  logic [IW-1:0]              wr_idx, rd_idx;
  blk_t                       prod;

  assign busy   = !ok_q && (step_q != '0) && (step_q < SW'(NPOW));
  assign upd    = load_i || busy;
  assign wr_idx = step_q[IW-1:0];
  assign rd_idx = wr_idx - IW'(1);

  // One shared multiplier: next power = previous power times H
  ghash4_gfmul u_mul (
    .a_i (pow_q[rd_idx]),
    .b_i (pow_q[0]),
    .p_o (prod)
  );

  always_comb begin
    pow_d  = pow_q;
    step_d = step_q;
    ok_d   = ok_q;
    if (load_i) begin
      pow_d[0] = hkey_i;
      step_d   = SW'(1);
      ok_d     = (NPOW == 1);
    end else if (busy) begin
      pow_d[wr_idx] = prod;
      step_d        = step_q + SW'(1);
      if (step_q == SW'(NPOW - 1)) ok_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pow_q  <= '0;
      step_q <= '0;
      ok_q   <= 1'b0;
    end else if (upd) begin
      pow_q  <= pow_d;
      step_q <= step_d;
      ok_q   <= ok_d;
    end
  end

  assign pow_o = pow_q;
  assign ok_o  = ok_q;

  // R2: a new subkey invalidates the powers
  assert_load_drops_ok_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !ok_o);

  // R2: once valid, powers stay valid until the next load
  assert_ok_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_o && !load_i) |=> ok_o);

endmodule

// File: rtl/ghash4_fold.sv
module ghash4_fold
  import ghash4_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [BLK_W-1:0]             acc_i,
  input  logic [LANES*BLK_W-1:0]       beat_i,
  input  logic                         last_i,
  input  logic [$clog2(LANES)-1:0]     nlm1_i,
  input  logic [LANES-1:0][BLK_W-1:0]  pow_i,
  output logic [BLK_W-1:0]             acc_o
);

  localparam int LW = $clog2(LANES);

  logic [LW-1:0]             top_idx;
  logic [LANES-1:0][BLK_W-1:0] prod;

  // Highest power index: last valid lane always lands on H
  assign top_idx = last_i ? nlm1_i : LW'(LANES - 1);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    blk_t          lane_blk;
    blk_t          lane_pow;
    logic          lane_ok;
    logic [LW-1:0] pidx;

    if (k == 0) begin : g_first
      assign lane_blk = beat_i[(LANES-1)*BLK_W +: BLK_W] ^ acc_i;
    end else begin : g_rest
      assign lane_blk = beat_i[(LANES-1-k)*BLK_W +: BLK_W];
    end

    assign lane_ok  = !last_i || (LW'(k) <= nlm1_i);
    assign pidx     = top_idx - LW'(k);
    assign lane_pow = lane_ok ? pow_i[pidx] : '0;

    ghash4_gfmul u_mul (
      .a_i (lane_blk),
      .b_i (lane_pow),
      .p_o (prod[k])
    );
  end

  always_comb begin
    acc_o = '0;
    for (int k = 0; k < LANES; k++) acc_o = acc_o ^ prod[k];
  end

endmodule

// File: rtl/ghash4_engine.sv
module ghash4_engine
  import ghash4_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic [127:0]                 hkey_i,
  input  logic                         beat_valid_i,
  input  logic                         beat_last_i,
  input  logic [$clog2(LANES)-1:0]     beat_lanes_i,
  input  logic [LANES*128-1:0]         beat_data_i,
  input  logic [63:0]                  aad_bits_i,
  input  logic [63:0]                  data_bits_i,
  input  logic [127:0]                 ekj0_i,
  input  logic [127:0]                 exp_tag_i,
  output logic                         ready_o,
  output logic                         done_o,
  output logic                         pass_o,
  output logic                         fail_o,
  output logic [127:0]                 tag_o
);

  logic [LANES-1:0][BLK_W-1:0] pow;
  logic                        pow_ok;

  phase_t ph_q, ph_d;
  blk_t   acc_q, acc_d;
  blk_t   len_q, len_d;
  blk_t   ej0_q, ej0_d;
  blk_t   exp_q, exp_d;
  blk_t   tag_q, tag_d;
  logic   done_q, done_d;
  logic   pass_q, pass_d;
  logic   fail_q, fail_d;

  blk_t   fold_out;
  blk_t   len_prod;
  blk_t   fin_tag;
  logic   ready_w;
  logic   accept;
  logic   acc_last;

  ghash4_hpow #(.NPOW(LANES)) u_hpow (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (start_i),
    .hkey_i (hkey_i),
    .pow_o  (pow),
    .ok_o   (pow_ok)
  );

  ghash4_fold #(.LANES(LANES)) u_fold (
    .acc_i  (acc_q),
    .beat_i (beat_data_i),
    .last_i (beat_last_i),
    .nlm1_i (beat_lanes_i),
    .pow_i  (pow),
    .acc_o  (fold_out)
  );

  ghash4_gfmul u_len (
    .a_i (acc_q ^ len_q),
    .b_i (pow[0]),
    .p_o (len_prod)
  );

  assign ready_w  = pow_ok && (ph_q == PH_RUN);
  assign accept   = beat_valid_i && ready_w && !start_i;
  assign acc_last = accept && beat_last_i;
  assign fin_tag  = acc_q ^ ej0_q;

  always_comb begin
    ph_d   = ph_q;
    acc_d  = acc_q;
    len_d  = len_q;
    ej0_d  = ej0_q;
    exp_d  = exp_q;
    tag_d  = tag_q;
    done_d = 1'b0;
    pass_d = 1'b0;
    fail_d = 1'b0;
    if (start_i) begin
      ph_d  = PH_RUN;
      acc_d = '0;
    end else begin
      unique case (ph_q)
        PH_RUN: begin
          if (accept) begin
            acc_d = fold_out;
            if (beat_last_i) begin
              ph_d  = PH_LEN;
              len_d = {aad_bits_i, data_bits_i};
              ej0_d = ekj0_i;
              exp_d = exp_tag_i;
            end
          end
        end
        PH_LEN: begin
          acc_d = len_prod;
          ph_d  = PH_FIN;
        end
        PH_FIN: begin
          tag_d  = fin_tag;
          done_d = 1'b1;
          pass_d = (fin_tag == exp_q);
          fail_d = (fin_tag != exp_q);
          acc_d  = '0;
          ph_d   = PH_RUN;
        end
        default: ph_d = PH_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_RUN;
      acc_q  <= '0;
      len_q  <= '0;
      ej0_q  <= '0;
      exp_q  <= '0;
      tag_q  <= '0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      acc_q  <= acc_d;
      len_q  <= len_d;
      ej0_q  <= ej0_d;
      exp_q  <= exp_d;
      tag_q  <= tag_d;
      done_q <= done_d;
      pass_q <= pass_d;
      fail_q <= fail_d;
    end
  end

  assign ready_o = ready_w;
  assign done_o  = done_q;
  assign pass_o  = pass_q;
  assign fail_o  = fail_q;
  assign tag_o   = tag_q;

  // R2: a start pulse always takes the engine out of ready
  assert_start_unready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !ready_o);

  // R9: two finalization cycles with ready low
  assert_final_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_last |=> !ready_o ##1 !ready_o);

  // R7: done arrives two edges after the last beat unless a start intervenes
  assert_done_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_last ##1 !start_i ##1 !start_i) |=> done_o);

  // R7: done is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: tag holds between done pulses
  assert_tag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(tag_o));

  // R8: exactly one verdict with done
  assert_one_verdict_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($countones({pass_o, fail_o}) == 1));

  // R8: no verdict without done
  assert_quiet_verdict_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> !(pass_o || fail_o));

endmodule

// File: tb/sim_ghash4_engine.sv
`timescale 1ns/1ps
module sim_ghash4_engine;

  logic         clk;
  logic         rst_n;
  logic         start_i;
  logic [127:0] hkey_i;
  logic         beat_valid_i;
  logic         beat_last_i;
  logic [1:0]   beat_lanes_i;
  logic [511:0] beat_data_i;
  logic [63:0]  aad_bits_i;
  logic [63:0]  data_bits_i;
  logic [127:0] ekj0_i;
  logic [127:0] exp_tag_i;
  logic         ready_o, done_o, pass_o, fail_o;
  logic [127:0] tag_o;

  int n_chk;
  int n_fail;
  bit cmp_en;

  ghash4_engine u0 (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .hkey_i (hkey_i),
    .beat_valid_i (beat_valid_i), .beat_last_i (beat_last_i),
    .beat_lanes_i (beat_lanes_i), .beat_data_i (beat_data_i),
    .aad_bits_i (aad_bits_i), .data_bits_i (data_bits_i),
    .ekj0_i (ekj0_i), .exp_tag_i (exp_tag_i),
    .ready_o (ready_o), .done_o (done_o), .pass_o (pass_o),
    .fail_o (fail_o), .tag_o (tag_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- reference arithmetic (polynomial form) ----------------
  function automatic logic [127:0] rev128(input logic [127:0] a);
    logic [127:0] r;
    for (int i = 0; i < 128; i++) r[i] = a[127-i];
    return r;
  endfunction

  function automatic logic [127:0] ref_mul(input logic [127:0] a, input logic [127:0] b);
    logic [254:0] p;
    logic [127:0] ar, br;
    ar = rev128(a);
    br = rev128(b);
    p = '0;
    for (int i = 0; i < 128; i++)
      if (ar[i]) p = p ^ ({127'd0, br} << i);
    for (int i = 254; i >= 128; i--)
      if (p[i]) begin
        p[i] = 1'b0;
        p = p ^ (255'h87 << (i - 128));
      end
    return rev128(p[127:0]);
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- cycle-by-cycle behavioural model ----------------
  logic [127:0] m_h, m_acc, m_len, m_ej, m_exp, m_tag;
  bit m_hok, m_done, m_pass, m_fail;
  int m_cnt, m_ph;

  always @(posedge clk) begin : model
    int n;
    if (!rst_n) begin
      m_hok = 0; m_cnt = 0; m_ph = 0; m_acc = '0; m_tag = '0; m_h = '0;
      m_done = 0; m_pass = 0; m_fail = 0;
    end else begin
      m_done = 0; m_pass = 0; m_fail = 0;
      if (start_i) begin
        m_h = hkey_i; m_hok = 1; m_cnt = 3; m_ph = 0; m_acc = '0;
      end else begin
        case (m_ph)
          0: if (beat_valid_i && m_hok && m_cnt == 0) begin
               n = beat_last_i ? int'(beat_lanes_i) + 1 : 4;
               for (int k = 0; k < n; k++)
                 m_acc = ref_mul(m_acc ^ beat_data_i[(3-k)*128 +: 128], m_h);
               if (beat_last_i) begin
                 m_len = {aad_bits_i, data_bits_i};
                 m_ej  = ekj0_i;
                 m_exp = exp_tag_i;
                 m_ph  = 1;
               end
             end
          1: begin m_acc = ref_mul(m_acc ^ m_len, m_h); m_ph = 2; end
          default: begin
            m_tag = m_acc ^ m_ej; m_done = 1; m_pass = (m_tag == m_exp);
            m_fail = !m_pass; m_acc = '0; m_ph = 0;
          end
        endcase
        if (m_cnt > 0) m_cnt--;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      bit m_rdy;
      m_rdy = m_hok && m_cnt == 0 && m_ph == 0;
      check(ready_o == m_rdy, "R2", "ready_o model", 128'(ready_o), 128'(m_rdy));
      check(done_o == m_done, "R7", "done_o model", 128'(done_o), 128'(m_done));
      check(pass_o == m_pass && fail_o == m_fail, "R8", "verdict model",
            128'({pass_o, fail_o}), 128'({m_pass, m_fail}));
      check(tag_o == m_tag, "R7", "tag_o model", tag_o, m_tag);
    end
  end

  // ---------------- stimulus helpers ----------------
  logic [127:0] cur_h;

  task automatic idle_inputs();
    start_i = 0; beat_valid_i = 0; beat_last_i = 0; beat_lanes_i = '0;
  endtask

  task automatic load_h(input logic [127:0] h);
    int n;
    @(negedge clk);
    start_i = 1; hkey_i = h; cur_h = h;
    beat_valid_i = 1; beat_data_i = {rnd128(), rnd128(), rnd128(), rnd128()};
    n = 0;
    forever begin
      @(negedge clk);
      start_i = 0;
      n++;
      if (ready_o || n > 10) break;
      beat_valid_i = 1; beat_last_i = n[0];
      beat_data_i = {rnd128(), rnd128(), rnd128(), rnd128()};
    end
    idle_inputs();
    check(n == 4, "R2", "cycles to ready", 128'(n), 128'(4));
  endtask

  task automatic send_msg(input int nblk, input logic [63:0] aadb, input bit corrupt,
                          input bit junk, input string req);
    logic [127:0] blks[$];
    logic [127:0] e, ej, want;
    int nbeat;
    for (int i = 0; i < nblk; i++) blks.push_back(rnd128());
    ej = rnd128();
    e = '0;
    foreach (blks[i]) e = ref_mul(e ^ blks[i], cur_h);
    e = ref_mul(e ^ {aadb, 64'(nblk * 128)}, cur_h);
    want = e ^ ej;
    nbeat = (nblk + 3) / 4;
    for (int b = 0; b < nbeat; b++) begin
      @(negedge clk);
      beat_valid_i = 1;
      beat_last_i  = (b == nbeat - 1);
      beat_lanes_i = beat_last_i ? 2'((nblk - 1) % 4) : 2'(3);
      for (int k = 0; k < 4; k++)
        beat_data_i[(3-k)*128 +: 128] = (b*4 + k < nblk) ? blks[b*4 + k] : rnd128();
      aad_bits_i  = aadb;
      data_bits_i = 64'(nblk * 128);
      ekj0_i      = ej;
      exp_tag_i   = corrupt ? (want ^ 128'h1) : want;
    end
    @(negedge clk);
    if (junk) begin
      beat_valid_i = 1; beat_last_i = 0;
      beat_data_i = {rnd128(), rnd128(), rnd128(), rnd128()};
      ekj0_i = rnd128(); exp_tag_i = rnd128(); aad_bits_i = '1;
    end else idle_inputs();
    check(ready_o == 0, "R9", "ready in finalize", 128'(ready_o), 128'(0));
    @(negedge clk);
    if (junk) begin
      beat_last_i = 1;
      beat_data_i = {rnd128(), rnd128(), rnd128(), rnd128()};
    end
    check(ready_o == 0, "R9", "ready in finalize", 128'(ready_o), 128'(0));
    @(negedge clk);
    idle_inputs();
    check(done_o == 1, "R7", "done after last", 128'(done_o), 128'(1));
    check(tag_o == want, req, "final tag", tag_o, want);
    check(pass_o == !corrupt && fail_o == corrupt, "R8", "verdict",
          128'({pass_o, fail_o}), 128'({!corrupt, corrupt}));
    @(negedge clk);
    check(done_o == 0 && ready_o == 1, "R10", "back to running",
          128'({done_o, ready_o}), 128'({1'b0, 1'b1}));
  endtask

  // ---------------- main sequence ----------------
  initial begin
    n_chk = 0; n_fail = 0; cmp_en = 0;
    rst_n = 0;
    idle_inputs();
    hkey_i = '0; beat_data_i = '0; aad_bits_i = '0; data_bits_i = '0;
    ekj0_i = '0; exp_tag_i = '0; cur_h = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cmp_en = 1;
    // R1: beats before any subkey are ignored
    beat_valid_i = 1; beat_last_i = 1;
    beat_data_i = {rnd128(), rnd128(), rnd128(), rnd128()};
    repeat (3) @(negedge clk);
    idle_inputs();
    check(ready_o == 0 && done_o == 0 && pass_o == 0 && fail_o == 0, "R1",
          "reset outputs", 128'({ready_o, done_o, pass_o, fail_o}), 128'(0));
    check(tag_o == '0, "R1", "reset tag", tag_o, '0);

    load_h(rnd128());
    send_msg(4, 64'd0, 0, 0, "R3");        // one full beat
    send_msg(13, 64'd0, 0, 1, "R4");       // back-to-back, last beat 1 lane, junk in finalize (R9)
    send_msg(6, 64'd0, 1, 0, "R5");        // last beat 2 lanes, corrupted expected tag
    send_msg(7, 64'd256, 0, 0, "R6");      // last beat 3 lanes, nonzero AAD length
    send_msg(1, 64'd128, 0, 0, "R10");     // single block right after previous message

    // R11: abandon a message mid-way
    for (int b = 0; b < 2; b++) begin
      @(negedge clk);
      beat_valid_i = 1; beat_last_i = 0;
      beat_data_i = {rnd128(), rnd128(), rnd128(), rnd128()};
    end
    load_h(rnd128());
    send_msg(8, 64'd0, 0, 0, "R11");
    send_msg(5, 64'd384, 0, 1, "R5");

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R4 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule